// File: doc/BRIEF.md
# PLL Coefficient Reprogramming Sequencer

This block changes the divider settings of a phase-locked loop without sending a glitch downstream. A request carries the settings now in use (reference divider, integer feedback divider, fractional word, post-divider code), a flag that says whether the loop is running, and the settings wanted next. The sequencer first halves the VCO output through a 1:2 output divider. It then picks one of two routes and at the end restores the 1:1 output divider.

The short route is used when the loop runs and only the post-divider differs. It rewrites the post-divider alone. If the old and new codes have no set bit in common, it first passes through a computed bridge code. Any other change takes the long route: the output goes to bypass, sync mode is cleared and the loop is switched off. All four settings are then written, the loop is switched back on and given a fixed settling time in place of a lock indication. Sync mode is restored and the VCO output is selected again.

All waits are counted in microsecond ticks made from the system clock by a parameterized prescaler. `start` is a plain request pin, sampled only while the block is idle. `done` pulses once when a request ends. Requests that arrive while `busy` is high are dropped, so a caller issues the next `start` only after `done`.

Top module: `pll_coeff_seq`

## Requirements
- R1: After reset every output is low or zero: the output divider is at 1:1 (`vco_div2`=0), the loop is off, sync mode is clear, bypass is selected (`vco_sel`=0), and the coefficient outputs are 0.
- R2: A `start` with `new_pl`=0 is rejected: on the next cycle `done` and `err` are both high for one cycle, and no output or strobe changes.
- R3: Every accepted request begins by setting `vco_div2`=1 with two `div_wr` strobes on consecutive cycles. No coefficient write and no enable, sync or select change follows until at least 2 µs (2·CLKS_PER_US cycles) after the second strobe.
- R4: The post-divider-only route is taken exactly when `pll_on`=1 and the M, N and fractional inputs match between the current and new sets. On that route `pll_en`, `sync_mode` and `vco_sel` do not change, and only `pl_out` is written.
- R5: On the post-divider-only route, if `cur_pl & new_pl` is nonzero, one `coeff_wr` writes `new_pl`. If it is zero, a first `coeff_wr` writes min(cur_pl | lowbit(new_pl), new_pl | lowbit(cur_pl)), where lowbit keeps only the least significant set bit, and a second writes `new_pl`.
- R6: On the full route, `vco_sel` falls first, then `sync_mode`, then `pll_en`. After that, one `coeff_wr` presents the new M, N, fractional and post-divider values together.
- R7: On the full route, `pll_en` rises after the coefficient write. `sync_mode` rises no earlier than 40 µs after `pll_en`, and `vco_sel` rises after `sync_mode`.
- R8: At least 2 µs after the last change of either route, `vco_div2` returns to 0 with two consecutive `div_wr` strobes. After that, `done` pulses with `err`=0.
- R9: A `start` seen while `busy` is high is ignored. Only one `done` results, and the outputs reflect the first request.
- R10: `done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| cur_m | input | M_W | Reference divider in use |
| cur_n | input | N_W | Integer feedback divider in use |
| cur_frac | input | F_W | Fractional word in use |
| cur_pl | input | PL_W | Post-divider code in use |
| pll_on | input | 1 | Loop currently running |
| new_m | input | M_W | Requested reference divider |
| new_n | input | N_W | Requested integer feedback divider |
| new_frac | input | F_W | Requested fractional word |
| new_pl | input | PL_W | Requested post-divider code (1..31, used as the divide value) |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | With done: request rejected |
| vco_div2 | output | 1 | VCO output divider: 1 = 1:2, 0 = 1:1 |
| div_wr | output | 1 | Strobe per output-divider write |
| coeff_wr | output | 1 | Strobe per coefficient write |
| m_out | output | M_W | Programmed reference divider |
| n_out | output | N_W | Programmed integer feedback divider |
| frac_out | output | F_W | Programmed fractional word |
| pl_out | output | PL_W | Programmed post-divider code |
| pll_en | output | 1 | Loop enable |
| sync_mode | output | 1 | Synchronous switch mode |
| vco_sel | output | 1 | 1 = VCO output, 0 = bypass |

## Verification
The hardest case to reach is a bridge code on the short route. It needs a running loop, identical M, N and fractional settings, and old and new post-divider codes that share no bit. The stimulus table chains requests so that each one's new set becomes the next one's current set. A full-route request switches the loop on first, and the following short-route rows step through disjoint pairs (3→4, 6→1, 12→3) as well as overlapping pairs. The 40 µs settling window is checked by timing the gap between the enable edge and the sync edge in cycles.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [4:0] {
    S_IDLE, S_DIVH1, S_DIVH2, S_WHEAD,
    S_PLMID, S_PLNEW,
    S_BYP, S_NOSYNC, S_OFF, S_PROG, S_ON, S_WLOCK, S_SYNC, S_VCO,
    S_WTAIL, S_DIVL1, S_DIVL2, S_FIN
  } seq_state_e;
endpackage

// File: rtl/pll_us_timer.sv
module pll_us_timer #(
  parameter int CLKS_PER_US = 4,
  parameter int LEN_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_us,
  output logic             expired
);
  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

  logic [PRE_W-1:0] pre_q;
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      pre_q  <= '0;
      left_q <= len_us;
    end else if (left_q != '0) begin
      if (pre_q == PRE_LAST) begin
        pre_q  <= '0;
        left_q <= left_q - LEN_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  assign expired = (left_q == '0);
endmodule

// File: rtl/pll_pl_bridge.sv
module pll_pl_bridge #(
  parameter int PL_W = 5
) (
  input  logic [PL_W-1:0] old_pl,
  input  logic [PL_W-1:0] tgt_pl,
  output logic            need_mid,
  output logic [PL_W-1:0] mid_pl
);
  logic [PL_W-1:0] low_old, low_tgt, cand_a, cand_b;

  always_comb begin
    low_old  = old_pl & (~old_pl + PL_W'(1));
    low_tgt  = tgt_pl & (~tgt_pl + PL_W'(1));
    cand_a   = old_pl | low_tgt;
    cand_b   = tgt_pl | low_old;
    mid_pl   = (cand_a < cand_b) ? cand_a : cand_b;
    need_mid = ((old_pl & tgt_pl) == '0);
  end
endmodule

// File: rtl/pll_path_pick.sv
module pll_path_pick #(
  parameter int M_W  = 8,
  parameter int N_W  = 8,
  parameter int F_W  = 8,
  parameter int PL_W = 5
) (
  input  logic [M_W-1:0]  cur_m,
  input  logic [N_W-1:0]  cur_n,
  input  logic [F_W-1:0]  cur_frac,
  input  logic            pll_on,
  input  logic [M_W-1:0]  new_m,
  input  logic [N_W-1:0]  new_n,
  input  logic [F_W-1:0]  new_frac,
  input  logic [PL_W-1:0] new_pl,
  output logic            pl_only,
  output logic            pl_legal
);
  always_comb begin
    pl_only  = pll_on && (cur_m == new_m) && (cur_n == new_n) && (cur_frac == new_frac);
    pl_legal = (new_pl != '0);
  end
endmodule

// File: rtl/pll_coeff_seq.sv
module pll_coeff_seq #(
  parameter int M_W         = 8,
  parameter int N_W         = 8,
  parameter int F_W         = 8,
  parameter int PL_W        = 5,
  parameter int CLKS_PER_US = 4,
  parameter int EDGE_US     = 2,
  parameter int LOCK_US     = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [M_W-1:0]  cur_m,
  input  logic [N_W-1:0]  cur_n,
  input  logic [F_W-1:0]  cur_frac,
  input  logic [PL_W-1:0] cur_pl,
  input  logic            pll_on,
  input  logic [M_W-1:0]  new_m,
  input  logic [N_W-1:0]  new_n,
  input  logic [F_W-1:0]  new_frac,
  input  logic [PL_W-1:0] new_pl,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            vco_div2,
  output logic            div_wr,
  output logic            coeff_wr,
  output logic [M_W-1:0]  m_out,
  output logic [N_W-1:0]  n_out,
  output logic [F_W-1:0]  frac_out,
  output logic [PL_W-1:0] pl_out,
  output logic            pll_en,
  output logic            sync_mode,
  output logic            vco_sel
);
  import pll_seq_pkg::*;

  localparam int LONGEST = (LOCK_US > EDGE_US) ? LOCK_US : EDGE_US;
  localparam int LEN_W   = $clog2(LONGEST + 1);

  seq_state_e state_q, state_d;

  logic            fast_q;
  logic [M_W-1:0]  lat_m;
  logic [N_W-1:0]  lat_n;
  logic [F_W-1:0]  lat_f;
  logic [PL_W-1:0] lat_pl, old_pl_q;

  logic            div2_q, divwr_q, cw_q, en_q, sync_q, vsel_q, done_q, err_q;
  logic [M_W-1:0]  m_q;
  logic [N_W-1:0]  n_q;
  logic [F_W-1:0]  f_q;
  logic [PL_W-1:0] pl_q;

  logic            pl_only, pl_legal, need_mid, tmr_exp, tmr_load;
  logic [PL_W-1:0] mid_pl;
  logic [LEN_W-1:0] tmr_len;

  pll_path_pick #(.M_W(M_W), .N_W(N_W), .F_W(F_W), .PL_W(PL_W)) u_pick (
    .cur_m(cur_m), .cur_n(cur_n), .cur_frac(cur_frac), .pll_on(pll_on),
    .new_m(new_m), .new_n(new_n), .new_frac(new_frac), .new_pl(new_pl),
    .pl_only(pl_only), .pl_legal(pl_legal)
  );

  pll_pl_bridge #(.PL_W(PL_W)) u_bridge (
    .old_pl(old_pl_q), .tgt_pl(lat_pl), .need_mid(need_mid), .mid_pl(mid_pl)
  );

  pll_us_timer #(.CLKS_PER_US(CLKS_PER_US), .LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len_us(tmr_len), .expired(tmr_exp)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:   if (start && pl_legal) state_d = S_DIVH1;
      S_DIVH1:  state_d = S_DIVH2;
      S_DIVH2:  state_d = S_WHEAD;
      S_WHEAD:  if (tmr_exp) state_d = fast_q ? (need_mid ? S_PLMID : S_PLNEW) : S_BYP;
      S_PLMID:  state_d = S_PLNEW;
      S_PLNEW:  state_d = S_WTAIL;
      S_BYP:    state_d = S_NOSYNC;
      S_NOSYNC: state_d = S_OFF;
      S_OFF:    state_d = S_PROG;
      S_PROG:   state_d = S_ON;
      S_ON:     state_d = S_WLOCK;
      S_WLOCK:  if (tmr_exp) state_d = S_SYNC;
      S_SYNC:   state_d = S_VCO;
      S_VCO:    state_d = S_WTAIL;
      S_WTAIL:  if (tmr_exp) state_d = S_DIVL1;
      S_DIVL1:  state_d = S_DIVL2;
      S_DIVL2:  state_d = S_FIN;
      S_FIN:    state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
    tmr_load = (state_d != state_q) &&
               ((state_d == S_WHEAD) || (state_d == S_WLOCK) || (state_d == S_WTAIL));
    tmr_len  = (state_d == S_WLOCK) ? LEN_W'(LOCK_US) : LEN_W'(EDGE_US);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      fast_q   <= 1'b0;
      lat_m    <= '0;
      lat_n    <= '0;
      lat_f    <= '0;
      lat_pl   <= '0;
      old_pl_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start && pl_legal) begin
        fast_q   <= pl_only;
        lat_m    <= new_m;
        lat_n    <= new_n;
        lat_f    <= new_frac;
        lat_pl   <= new_pl;
        old_pl_q <= cur_pl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div2_q  <= 1'b0;
      divwr_q <= 1'b0;
      cw_q    <= 1'b0;
      en_q    <= 1'b0;
      sync_q  <= 1'b0;
      vsel_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      m_q     <= '0;
      n_q     <= '0;
      f_q     <= '0;
      pl_q    <= '0;
    end else begin
      divwr_q <= 1'b0;
      cw_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      case (state_q)
        S_IDLE: if (start && !pl_legal) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end
        S_DIVH1, S_DIVH2: begin
          div2_q  <= 1'b1;
          divwr_q <= 1'b1;
        end
        S_PLMID: begin
          pl_q <= mid_pl;
          cw_q <= 1'b1;
        end
        S_PLNEW: begin
          pl_q <= lat_pl;
          cw_q <= 1'b1;
        end
        S_BYP:    vsel_q <= 1'b0;
        S_NOSYNC: sync_q <= 1'b0;
        S_OFF:    en_q   <= 1'b0;
        S_PROG: begin
          m_q  <= lat_m;
          n_q  <= lat_n;
          f_q  <= lat_f;
          pl_q <= lat_pl;
          cw_q <= 1'b1;
        end
        S_ON:     en_q   <= 1'b1;
        S_SYNC:   sync_q <= 1'b1;
        S_VCO:    vsel_q <= 1'b1;
        S_DIVL1, S_DIVL2: begin
          div2_q  <= 1'b0;
          divwr_q <= 1'b1;
        end
        S_FIN:    done_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign vco_div2  = div2_q;
  assign div_wr    = divwr_q;
  assign coeff_wr  = cw_q;
  assign m_out     = m_q;
  assign n_out     = n_q;
  assign frac_out  = f_q;
  assign pl_out    = pl_q;
  assign pll_en    = en_q;
  assign sync_mode = sync_q;
  assign vco_sel   = vsel_q;
endmodule

// File: rtl/pll_coeff_seq_chk.sv
module pll_coeff_seq_chk #(
  parameter int CLKS_PER_US = 4,
  parameter int LOCK_US     = 40
) (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic err,
  input logic vco_div2,
  input logic div_wr,
  input logic coeff_wr,
  input logic pll_en,
  input logic sync_mode,
  input logic vco_sel
);
  localparam int LOCK_CYC = LOCK_US * CLKS_PER_US;
  localparam int CW       = $clog2(LOCK_CYC + 4);

  logic [CW-1:0] on_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    on_cnt <= '0;
    else if (!pll_en)              on_cnt <= '0;
    else if (on_cnt < CW'(LOCK_CYC)) on_cnt <= on_cnt + CW'(1);
  end

  p_err_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_div_pair_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vco_div2) |-> div_wr);

  p_div_pair_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vco_div2) |=> div_wr);

  p_coeff_under_div2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    coeff_wr |-> vco_div2);

  p_enable_under_div2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> vco_div2);

  p_off_after_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> (!vco_sel && !sync_mode));

  p_sync_after_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_mode) |-> (pll_en && on_cnt >= CW'(LOCK_CYC)));

  p_vco_after_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vco_sel) |-> (sync_mode && pll_en));

  p_restore_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vco_div2) |=> div_wr);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind pll_coeff_seq pll_coeff_seq_chk #(.CLKS_PER_US(CLKS_PER_US), .LOCK_US(LOCK_US)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err), .vco_div2(vco_div2),
  .div_wr(div_wr), .coeff_wr(coeff_wr), .pll_en(pll_en),
  .sync_mode(sync_mode), .vco_sel(vco_sel)
);

// File: tb/sim_pll_coeff_seq.sv
module sim_pll_coeff_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;
  localparam int EDGE_CYC   = 2 * CPU;
  localparam int LOCK_CYC   = 40 * CPU;

  typedef struct packed {
    logic [7:0] cm; logic [7:0] cn; logic [7:0] cf; logic [4:0] cp; logic on;
    logic [7:0] nm; logic [7:0] nn; logic [7:0] nf; logic [4:0] np;
    logic fast; logic [4:0] mid;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{8'd1, 8'd10, 8'd0, 5'd1,  1'b0, 8'd2, 8'd20, 8'd5, 5'd3,  1'b0, 5'd0},
    '{8'd2, 8'd20, 8'd5, 5'd3,  1'b1, 8'd2, 8'd20, 8'd5, 5'd4,  1'b1, 5'd5},
    '{8'd2, 8'd20, 8'd5, 5'd4,  1'b1, 8'd2, 8'd20, 8'd5, 5'd6,  1'b1, 5'd0},
    '{8'd2, 8'd20, 8'd5, 5'd6,  1'b1, 8'd2, 8'd20, 8'd5, 5'd1,  1'b1, 5'd3},
    '{8'd2, 8'd20, 8'd5, 5'd1,  1'b1, 8'd2, 8'd20, 8'd5, 5'd31, 1'b1, 5'd0},
    '{8'd2, 8'd20, 8'd5, 5'd31, 1'b1, 8'd2, 8'd20, 8'd6, 5'd31, 1'b0, 5'd0},
    '{8'd2, 8'd20, 8'd6, 5'd31, 1'b1, 8'd3, 8'd20, 8'd6, 5'd16, 1'b0, 5'd0},
    '{8'd3, 8'd20, 8'd6, 5'd16, 1'b1, 8'd3, 8'd21, 8'd6, 5'd16, 1'b0, 5'd0},
    '{8'd3, 8'd21, 8'd6, 5'd16, 1'b0, 8'd3, 8'd21, 8'd6, 5'd8,  1'b0, 5'd0},
    '{8'd3, 8'd21, 8'd6, 5'd8,  1'b1, 8'd3, 8'd21, 8'd6, 5'd12, 1'b1, 5'd0},
    '{8'd3, 8'd21, 8'd6, 5'd12, 1'b1, 8'd3, 8'd21, 8'd6, 5'd3,  1'b1, 5'd7}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pll_on = 1'b0;
  logic [7:0] cur_m = '0, cur_n = '0, cur_frac = '0, new_m = '0, new_n = '0, new_frac = '0;
  logic [4:0] cur_pl = '0, new_pl = '0;
  logic busy, done, err, vco_div2, div_wr, coeff_wr, pll_en, sync_mode, vco_sel;
  logic [7:0] m_out, n_out, frac_out;
  logic [4:0] pl_out;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_coeff_seq #(.CLKS_PER_US(CPU)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cur_m(cur_m), .cur_n(cur_n),
    .cur_frac(cur_frac), .cur_pl(cur_pl), .pll_on(pll_on), .new_m(new_m),
    .new_n(new_n), .new_frac(new_frac), .new_pl(new_pl), .busy(busy), .done(done),
    .err(err), .vco_div2(vco_div2), .div_wr(div_wr), .coeff_wr(coeff_wr),
    .m_out(m_out), .n_out(n_out), .frac_out(frac_out), .pl_out(pl_out),
    .pll_en(pll_en), .sync_mode(sync_mode), .vco_sel(vco_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {vco_div2, pll_en, sync_mode, vco_sel, m_out, n_out, frac_out, pl_out};
  endfunction

  task automatic drive(input vec_t v, input int vid);
    cur_m = v.cm; cur_n = v.cn; cur_frac = v.cf; cur_pl = v.cp; pll_on = v.on;
    new_m = v.nm; new_n = v.nn; new_frac = v.nf; new_pl = v.np;
    vid = vid;
  endtask

  task automatic run_vec(input int i);
    vec_t v = VT[i];
    int d_cnt = 0, d2 = -1, d3 = -1, d4 = -1, cw_n = 0, first_chg = -1, last_chg = -1;
    int vf = -1, sf = -1, ef = -1, er = -1, sr = -1, vr = -1;
    logic [4:0] pw0 = '0, pw1 = '0;
    logic pv, ps, pe, was_en;
    bit got = 1'b0;
    @(negedge clk);
    drive(v, i);
    was_en = pll_en; pv = vco_sel; ps = sync_mode; pe = pll_en;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 2000 && !got; k++) begin
      @(negedge clk);
      if (div_wr) begin
        d_cnt++;
        if (d_cnt == 2) d2 = k;
        if (d_cnt == 3) d3 = k;
        if (d_cnt == 4) d4 = k;
      end
      if (coeff_wr) begin
        if (cw_n == 0) pw0 = pl_out;
        if (cw_n == 1) pw1 = pl_out;
        cw_n++;
        if (first_chg < 0) first_chg = k;
        last_chg = k;
      end
      if (vco_sel != pv) begin
        if (vco_sel) vr = k; else vf = k;
        if (first_chg < 0) first_chg = k;
        last_chg = k;
      end
      if (sync_mode != ps) begin
        if (sync_mode) sr = k; else sf = k;
        if (first_chg < 0) first_chg = k;
        last_chg = k;
      end
      if (pll_en != pe) begin
        if (pll_en) er = k; else ef = k;
        if (first_chg < 0) first_chg = k;
        last_chg = k;
      end
      pv = vco_sel; ps = sync_mode; pe = pll_en;
      if (done) begin
        got = 1'b1;
        chk(!err, "R8 err low at done", int'(err), 0);
        chk(!vco_div2, "R8 divider back to 1:1", int'(vco_div2), 0);
        chk(d_cnt == 4, "R8 four divider writes", d_cnt, 4);
        chk(d4 == d3 + 1, "R8 restore writes consecutive", d4, d3 + 1);
        chk(d3 - last_chg >= EDGE_CYC, "R8 tail wait", d3 - last_chg, EDGE_CYC);
      end
    end
    chk(got, "R10 done seen", int'(got), 1);
    chk(first_chg - d2 >= EDGE_CYC, "R3 head wait", first_chg - d2, EDGE_CYC);
    chk(pl_out == v.np, "R5 final pl", int'(pl_out), int'(v.np));
    if (v.fast) begin
      chk(ef < 0 && er < 0 && vf < 0 && sf < 0, "R4 no control toggles on short route", ef, -1);
      chk(m_out == v.nm && n_out == v.nn && frac_out == v.nf, "R4 M/N/frac untouched", int'(m_out), int'(v.nm));
      if (v.mid != 0) begin
        chk(cw_n == 2, "R5 two pl writes", cw_n, 2);
        chk(pw0 == v.mid, "R5 bridge code", int'(pw0), int'(v.mid));
        chk(pw1 == v.np, "R5 second write is new", int'(pw1), int'(v.np));
      end else begin
        chk(cw_n == 1, "R5 single pl write", cw_n, 1);
      end
    end else begin
      chk(cw_n == 1, "R6 one coefficient write", cw_n, 1);
      chk(m_out == v.nm && n_out == v.nn && frac_out == v.nf, "R6 coefficients", int'(n_out), int'(v.nn));
      if (was_en) chk(vf >= 0 && vf < sf && sf < ef && ef < first_chg + 100 && ef < er,
                      "R6 shutdown order", sf, vf + 1);
      chk(er > 0 && sr - er >= LOCK_CYC, "R7 settle time", sr - er, LOCK_CYC);
      chk(vr > sr, "R7 vco select after sync", vr, sr + 1);
      chk(pll_en && sync_mode && vco_sel, "R7 running at end", int'(pll_en), 1);
    end
    @(negedge clk);
    chk(!done, "R10 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    int dn;
    bit strobe;
    repeat (3) @(negedge clk);
    chk(outs() == 32'd0 && !busy && !done && !div_wr && !coeff_wr, "R1 reset state", int'(outs()), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outs() == 32'd0, "R1 after release", int'(outs()), 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R2: zero post-divider rejected
    snap = outs();
    new_pl = 5'd0; new_m = 8'd9; pll_on = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && err, "R2 reject pulse", int'({done, err}), 3);
    strobe = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (div_wr || coeff_wr || busy) strobe = 1'b1;
    end
    chk(!strobe, "R2 no strobes", int'(strobe), 0);
    chk(outs() == snap, "R2 outputs unchanged", int'(outs()), int'(snap));

    // R9: second start while busy is dropped
    cur_m = m_out; cur_n = n_out; cur_frac = frac_out; cur_pl = pl_out; pll_on = 1'b1;
    new_m = m_out; new_n = n_out; new_frac = frac_out; new_pl = 5'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    new_pl = 5'd17; new_m = 8'd77;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dn = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (done) dn++;
    end
    chk(dn == 1, "R9 one done", dn, 1);
    chk(pl_out == 5'd2 && m_out != 8'd77, "R9 first request kept", int'(pl_out), 2);
    chk(!busy, "R9 idle after", int'(busy), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule